// File: doc/BRIEF.md
# Disk Data Register Handshake with Lost-Byte Detection

This block sits between the host (or a DMA engine) and the serial shift logic of a disk controller and owns the single data byte register that both sides share. During a disk read, the shift side delivers each assembled byte with a strobe. The block stores the byte and raises a data request, which stays up until the host reads the register. During a disk write, the shift side strobes each time it needs the next byte. The block hands over the held byte and raises a data request, which stays up until the host loads a new byte.

When the host falls behind, the transfer is not stalled. On a read, a byte that arrives while the previous one is still unread overwrites it and sets a lost-data flag. On a write, a strobe that finds no fresh byte sends all zeros to the shift side and sets the same flag. The flag is sticky. It is cleared only by the start pulse that opens a new command, and that pulse also drops the data request. Both flags are also placed in a status word at fixed bit positions.

Top module: `drq_xfer_ctrl`

## Requirements
- R1: In read mode (`mode_wr_i`=0), a `shift_stb_i` pulse loads `shift_rdata_i` into the data register and sets `drq_o`. Both are visible on `host_rdata_o` and `drq_o` after that clock edge.
- R2: In read mode, a `host_rd_i` pulse with no strobe in the same cycle clears `drq_o` at the next edge. When a strobe comes in the same cycle, the strobe is applied last and `drq_o` stays set.
- R3: In read mode, a strobe that arrives while `drq_o` is 1 and without a host read in the same cycle sets `lost_o`, and the new byte still replaces the old one. A strobe that coincides with a host read does not set `lost_o`.
- R4: In write mode (`mode_wr_i`=1), a strobe sets `drq_o`. If `drq_o` was 0 in that cycle, `shift_wdata_o` presents the held data byte.
- R5: In write mode, a `host_wr_i` pulse loads `host_wdata_i` and clears `drq_o`. If a strobe comes in the same cycle, the new byte appears directly on `shift_wdata_o`, `drq_o` ends set, and `lost_o` is not set.
- R6: In write mode, a strobe with `drq_o`=1 and no host write in the same cycle drives `shift_wdata_o` to all zeros and sets `lost_o`.
- R7: `status_o` carries `drq_o` at bit 1 and `lost_o` at bit 2. All other bits are 0.
- R8: `lost_o` stays set until `start_i` is pulsed. A `start_i` pulse clears `drq_o` and `lost_o` at the next edge, and any strobe or host access in the same cycle is ignored, so the data register is unchanged.
- R9: A host write in read mode leaves the data register unchanged. A host read in write mode leaves `drq_o` unchanged.
- R10: After reset, `drq_o`, `lost_o` and the data register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | New-command pulse; clears the flags |
| mode_wr_i | input | 1 | 0 = disk read, 1 = disk write |
| host_rd_i | input | 1 | Host or DMA reads the data register |
| host_wr_i | input | 1 | Host or DMA loads the data register |
| host_wdata_i | input | DATA_W | Byte written by the host |
| host_rdata_o | output | DATA_W | Current data register content |
| shift_stb_i | input | 1 | Shift side has a byte ready (read) or needs a byte (write) |
| shift_rdata_i | input | DATA_W | Assembled byte from the shift side |
| shift_wdata_o | output | DATA_W | Byte handed to the shift side on a write strobe |
| drq_o | output | 1 | Data request |
| lost_o | output | 1 | Sticky lost-data flag |
| status_o | output | STAT_W | Status word with the data request and lost-data bits |

## Verification
The bench builds the block with its defaults: an 8-bit data path and an 8-bit status word with the flags at bits 1 and 2. With these values, randomly drawn bytes cover the whole byte space, so a zero substituted on underrun can be told apart from held data. The unused status bits can also be checked to stay at zero. Random cycles make host accesses and strobes coincide often, which exercises the same-cycle ordering in both modes. Directed sequences cover the start pulse colliding with a strobe and the host accesses that must be ignored.

// File: rtl/drq_pkg.sv
package drq_pkg;
  typedef enum logic {
    XFER_RD = 1'b0,
    XFER_WR = 1'b1
  } xfer_mode_e;

  typedef struct packed {
    logic rd_take;  // read-mode byte arrives from shift side
    logic rd_ack;   // host reads in read mode
    logic wr_load;  // host loads in write mode
    logic wr_take;  // write-mode shift side takes a byte
  } xfer_evt_t;
endpackage

// File: rtl/drq_evt_qual.sv
module drq_evt_qual
  import drq_pkg::*;
(
  input  logic       start_i,
  input  xfer_mode_e mode_i,
  input  logic       host_rd_i,
  input  logic       host_wr_i,
  input  logic       shift_stb_i,
  output xfer_evt_t  evt_o
);
  logic live;
  assign live = ~start_i;

  always_comb begin
    evt_o.rd_take = live & (mode_i == XFER_RD) & shift_stb_i;
    evt_o.rd_ack  = live & (mode_i == XFER_RD) & host_rd_i;
    evt_o.wr_load = live & (mode_i == XFER_WR) & host_wr_i;
    evt_o.wr_take = live & (mode_i == XFER_WR) & shift_stb_i;
  end
endmodule

// File: rtl/drq_data_reg.sv
module drq_data_reg
  import drq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_evt_t         evt_i,
  input  logic              drq_i,
  input  logic [DATA_W-1:0] shift_rdata_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] shift_wdata_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             data_q <= '0;
    else if (evt_i.rd_take)  data_q <= shift_rdata_i;
    else if (evt_i.wr_load)  data_q <= host_wdata_i;
  end

  // same-cycle host load bypasses the register; stale request means underrun
  always_comb begin
    if (evt_i.wr_load)  shift_wdata_o = host_wdata_i;
    else if (drq_i)     shift_wdata_o = '0;
    else                shift_wdata_o = data_q;
  end

  assign data_o = data_q;
endmodule

// File: rtl/drq_flag_ctl.sv
module drq_flag_ctl
  import drq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  xfer_evt_t evt_i,
  output logic      drq_o,
  output logic      lost_o
);
  logic drq_q, lost_q, drq_d, lost_d;

  // host side first, shift side last
  always_comb begin
    drq_d  = drq_q;
    lost_d = lost_q;
    if (evt_i.rd_ack || evt_i.wr_load) drq_d = 1'b0;
    if (evt_i.rd_take) begin
      if (drq_q && !evt_i.rd_ack) lost_d = 1'b1;
      drq_d = 1'b1;
    end
    if (evt_i.wr_take) begin
      if (drq_q && !evt_i.wr_load) lost_d = 1'b1;
      drq_d = 1'b1;
    end
    if (start_i) begin
      drq_d  = 1'b0;
      lost_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drq_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      drq_q  <= drq_d;
      lost_q <= lost_d;
    end
  end

  assign drq_o  = drq_q;
  assign lost_o = lost_q;
endmodule

// File: rtl/drq_stat_pack.sv
module drq_stat_pack #(
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned DRQ_POS  = 1,
  parameter int unsigned LOST_POS = 2
) (
  input  logic              drq_i,
  input  logic              lost_i,
  output logic [STAT_W-1:0] status_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == DRQ_POS) begin : g_drq
      assign status_o[b] = drq_i;
    end else if (b == LOST_POS) begin : g_lost
      assign status_o[b] = lost_i;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/drq_xfer_ctrl.sv
module drq_xfer_ctrl
  import drq_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned DRQ_POS  = 1,
  parameter int unsigned LOST_POS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_wr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              shift_stb_i,
  input  logic [DATA_W-1:0] shift_rdata_i,
  output logic [DATA_W-1:0] shift_wdata_o,
  output logic              drq_o,
  output logic              lost_o,
  output logic [STAT_W-1:0] status_o
);
  xfer_evt_t  evt;
  xfer_mode_e mode;
  logic       drq, lost;

  assign mode = xfer_mode_e'(mode_wr_i);

  drq_evt_qual u_qual (
    .start_i    (start_i),
    .mode_i     (mode),
    .host_rd_i  (host_rd_i),
    .host_wr_i  (host_wr_i),
    .shift_stb_i(shift_stb_i),
    .evt_o      (evt)
  );

  drq_flag_ctl u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .evt_i  (evt),
    .drq_o  (drq),
    .lost_o (lost)
  );

  drq_data_reg #(.DATA_W(DATA_W)) u_dreg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .drq_i        (drq),
    .shift_rdata_i(shift_rdata_i),
    .host_wdata_i (host_wdata_i),
    .data_o       (host_rdata_o),
    .shift_wdata_o(shift_wdata_o)
  );

  drq_stat_pack #(.STAT_W(STAT_W), .DRQ_POS(DRQ_POS), .LOST_POS(LOST_POS)) u_stat (
    .drq_i   (drq),
    .lost_i  (lost),
    .status_o(status_o)
  );

  assign drq_o  = drq;
  assign lost_o = lost;
endmodule

// File: rtl/drq_xfer_chk.sv
module drq_xfer_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned DRQ_POS  = 1,
  parameter int unsigned LOST_POS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mode_wr_i,
  input logic              host_rd_i,
  input logic              host_wr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              shift_stb_i,
  input logic [DATA_W-1:0] shift_rdata_i,
  input logic [DATA_W-1:0] shift_wdata_o,
  input logic              drq_o,
  input logic              lost_o,
  input logic [STAT_W-1:0] status_o
);
  p_rd_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !mode_wr_i && shift_stb_i) |=> (drq_o && host_rdata_o == $past(shift_rdata_i)));

  p_rd_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !mode_wr_i && host_rd_i && !shift_stb_i) |=> !drq_o);

  p_overrun_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !mode_wr_i && shift_stb_i && drq_o && !host_rd_i) |=> lost_o);

  p_wr_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && mode_wr_i && shift_stb_i) |=> drq_o);

  p_wr_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && mode_wr_i && host_wr_i && shift_stb_i) |-> shift_wdata_o == host_wdata_i);

  p_wr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && mode_wr_i && host_wr_i && !shift_stb_i) |=> (!drq_o && host_rdata_o == $past(host_wdata_i)));

  p_zero_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && mode_wr_i && shift_stb_i && drq_o && !host_wr_i) |-> shift_wdata_o == '0);

  p_underrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && mode_wr_i && shift_stb_i && drq_o && !host_wr_i) |=> lost_o);

  p_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[DRQ_POS] == drq_o) && (status_o[LOST_POS] == lost_o)
    && ($countones(status_o) == int'(drq_o) + int'(lost_o)));

  p_lost_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && lost_o) |=> lost_o);

  p_start_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!drq_o && !lost_o && $stable(host_rdata_o)));

  p_rd_ign_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_wr_i && host_wr_i && !shift_stb_i) |=> $stable(host_rdata_o));
endmodule

bind drq_xfer_ctrl drq_xfer_chk #(
  .DATA_W(DATA_W), .STAT_W(STAT_W), .DRQ_POS(DRQ_POS), .LOST_POS(LOST_POS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_wr_i    (mode_wr_i),
  .host_rd_i    (host_rd_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .shift_stb_i  (shift_stb_i),
  .shift_rdata_i(shift_rdata_i),
  .shift_wdata_o(shift_wdata_o),
  .drq_o        (drq_o),
  .lost_o       (lost_o),
  .status_o     (status_o)
);

// File: tb/tb_drq_xfer_ctrl.sv
module tb_drq_xfer_ctrl;
  localparam int unsigned DW = 8;
  localparam int unsigned SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, mode_wr = 1'b0, hrd = 1'b0, hwr = 1'b0, stb = 1'b0;
  logic [DW-1:0] hwdata = '0, srdata = '0;
  logic [DW-1:0] hrdata, swdata;
  logic          drq, lost;
  logic [SW-1:0] status;

  int n_chk = 0, n_bad = 0;

  // expected state
  logic [DW-1:0] m_dr = '0;
  logic          m_drq = 1'b0, m_lost = 1'b0;

  always #10 clk = ~clk;

  drq_xfer_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_wr_i(mode_wr),
    .host_rd_i(hrd), .host_wr_i(hwr), .host_wdata_i(hwdata), .host_rdata_o(hrdata),
    .shift_stb_i(stb), .shift_rdata_i(srdata), .shift_wdata_o(swdata),
    .drq_o(drq), .lost_o(lost), .status_o(status)
  );

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_status(input logic d, input logic l);
    logic [SW-1:0] s;
    s = '0;
    s[1] = d;
    s[2] = l;
    return s;
  endfunction

  function automatic logic [DW-1:0] exp_out(input logic w, input logic [DW-1:0] wd,
                                            input logic q, input logic [DW-1:0] dr);
    if (w) return wd;
    if (q) return '0;
    return dr;
  endfunction

  task automatic check_outs(input string req);
    cmp(req, "host_rdata", 32'(hrdata), 32'(m_dr));
    cmp(req, "drq", 32'(drq), 32'(m_drq));
    cmp(req, "lost", 32'(lost), 32'(m_lost));
    cmp("R7", "status", 32'(status), 32'(exp_status(m_drq, m_lost)));
  endtask

  task automatic step(input logic st, input logic md, input logic hr, input logic hw,
                      input logic [DW-1:0] wd, input logic sb, input logic [DW-1:0] sd);
    string tag;
    logic  n_drq, n_lost;
    logic [DW-1:0] n_dr;
    @(negedge clk);
    start = st; mode_wr = md; hrd = hr; hwr = hw; hwdata = wd; stb = sb; srdata = sd;
    #1;
    if (!st && md && sb) begin
      if (hw)         tag = "R5";
      else if (m_drq) tag = "R6";
      else            tag = "R4";
      cmp(tag, "shift_wdata", 32'(swdata), 32'(exp_out(hw, wd, m_drq, m_dr)));
    end
    n_drq = m_drq; n_lost = m_lost; n_dr = m_dr; tag = "R9";
    if (st) begin
      n_drq = 1'b0; n_lost = 1'b0; tag = "R8";
    end else if (!md) begin
      if (hr) begin n_drq = 1'b0; tag = "R2"; end
      if (sb) begin
        if (m_drq && !hr) n_lost = 1'b1;
        n_drq = 1'b1; n_dr = sd;
        tag = (m_drq && !hr) ? "R3" : "R1";
      end
    end else begin
      if (hw) begin n_drq = 1'b0; n_dr = wd; tag = "R5"; end
      if (sb) begin
        if (m_drq && !hw) n_lost = 1'b1;
        n_drq = 1'b1;
        tag = (m_drq && !hw) ? "R6" : (hw ? "R5" : "R4");
      end
    end
    @(posedge clk);
    #2;
    m_drq = n_drq; m_lost = n_lost; m_dr = n_dr;
    start = 1'b0; hrd = 1'b0; hwr = 1'b0; stb = 1'b0;
    check_outs(tag);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    cmp("R10", "drq", 32'(drq), 0);
    cmp("R10", "lost", 32'(lost), 0);
    cmp("R10", "host_rdata", 32'(hrdata), 0);
    cmp("R10", "status", 32'(status), 0);
    rst_n = 1'b1;

    // read path
    step(0, 0, 0, 0, 8'h00, 1, 8'hA5);            // R1
    cmp("R1", "drq set", 32'(drq), 1);
    step(0, 0, 1, 0, 8'h00, 0, 8'h00);            // R2
    cmp("R2", "drq clear", 32'(drq), 0);
    step(0, 0, 0, 0, 8'h00, 1, 8'h3C);
    step(0, 0, 1, 0, 8'h00, 1, 8'h77);            // read and strobe together
    cmp("R3", "no loss on coincident read", 32'(lost), 0);
    cmp("R2", "drq kept by strobe", 32'(drq), 1);
    step(0, 0, 0, 0, 8'h00, 1, 8'hC3);            // overrun
    cmp("R3", "lost set", 32'(lost), 1);
    cmp("R3", "new byte kept", 32'(hrdata), 32'hC3);
    step(0, 0, 0, 1, 8'h5A, 0, 8'h00);            // R9 host write ignored in read mode
    cmp("R9", "data unchanged", 32'(hrdata), 32'hC3);
    step(0, 0, 1, 0, 8'h00, 0, 8'h00);
    cmp("R8", "lost sticky", 32'(lost), 1);
    step(1, 0, 0, 0, 8'h00, 1, 8'h11);            // start with strobe
    cmp("R8", "start clears lost", 32'(lost), 0);
    cmp("R8", "strobe ignored", 32'(hrdata), 32'hC3);

    // write path
    step(0, 1, 0, 1, 8'h96, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00, 1, 8'h00);            // R4 hands 96
    cmp("R4", "drq set", 32'(drq), 1);
    step(0, 1, 1, 0, 8'h00, 0, 8'h00);            // R9 read ignored in write mode
    cmp("R9", "drq unchanged", 32'(drq), 1);
    step(0, 1, 0, 0, 8'h00, 1, 8'h00);            // R6 underrun
    cmp("R6", "lost set", 32'(lost), 1);
    step(1, 1, 0, 0, 8'h00, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00, 1, 8'h00);
    step(0, 1, 0, 1, 8'h4E, 1, 8'h00);            // R5 bypass
    cmp("R5", "no loss", 32'(lost), 0);
    cmp("R5", "drq set", 32'(drq), 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic md;
      md = (i / 500) % 2 == 1;
      step(($urandom % 40) == 0, md, ($urandom % 3) == 0, ($urandom % 3) == 0,
           8'($urandom), ($urandom % 2) == 0, 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule